// File: doc/BRIEF.md
# Supply-Loss Write Guard and Backup Power Sequencer

This block sits beside a battery-backed memory and decides, from three digital supply-level flags produced by external comparators, whether the memory may be used. The three flags report whether the supply is above an upper power-fail level, above a lower power-fail level, and above a battery changeover level. The block conditions each flag against noise and then runs a four-state controller. The states are normal, deselected, on battery and recovering. The controller drives write protection, output tri-state, backup-power selection and a ready indication.

As the supply sags into the power-fail window, the memory is cut off at once. The write strobe is gated off, the data outputs are floated, and further strobes are only noted. Below the changeover level the backup source is selected. When power returns, the external source is chosen again as soon as the changeover level is passed. Protection, however, stays in force for a programmable number of clock cycles after the supply clears the upper power-fail level. That count starts over if the supply falls back into the window during the wait. Because the strobe is gated in the same cycle that protection rises, a supply loss during a write can only damage the word being written.

Top module: `pwrfail_guard`

## Requirements
- R1: While reset is held, and on the first cycle after it, the outputs are wr_protect_o=1, out_hiz_o=1, bat_sel_o=1, ready_o=0, wr_en_o=0 and wr_blocked_o=0.
- R2: With the settled supply below the upper power-fail level but above the changeover level, wr_protect_o=1, out_hiz_o=1, ready_o=0 and bat_sel_o=0.
- R3: With the settled battery-level flag low, bat_sel_o=1 and wr_protect_o=1, whatever the other two flags show.
- R4: Once the battery-level flag has been high for FILT_LEN cycles, bat_sel_o is 0, and it stays 0 while recovery is still in progress.
- R5: When all three flags rise together from a settled low supply, ready_o first reads 1 after exactly FILT_LEN+REC_CYCLES+3 rising clock edges. wr_protect_o stays 1 until then.
- R6: If the upper flag falls for FILT_LEN or more cycles during recovery, the recovery count is discarded. After the flag returns, the full FILT_LEN+REC_CYCLES+3 edge delay applies again, and ready_o stays 0 throughout.
- R7: A change on any flag that lasts fewer than FILT_LEN cycles has no effect on any output. A change that lasts FILT_LEN cycles or more takes effect.
- R8: wr_en_o equals wr_strobe_i in the same cycle while ready_o=1, and is 0 while wr_protect_o=1.
- R9: wr_blocked_o becomes 1 on the clock edge after a cycle in which wr_strobe_i=1 and wr_protect_o=1. It then stays 1 until reset.
- R10: In normal operation after recovery, wr_protect_o=0, out_hiz_o=0, bat_sel_o=0 and ready_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_above_hi_i | input | 1 | Supply above upper power-fail level (asynchronous) |
| sup_above_lo_i | input | 1 | Supply above lower power-fail level (asynchronous) |
| sup_above_bat_i | input | 1 | Supply above battery changeover level (asynchronous) |
| wr_strobe_i | input | 1 | Write request from the memory user |
| wr_en_o | output | 1 | Gated write enable to the memory array |
| wr_protect_o | output | 1 | Memory write-protected |
| out_hiz_o | output | 1 | Memory data outputs floated |
| bat_sel_o | output | 1 | Backup battery selected as the memory supply |
| ready_o | output | 1 | Normal read and write operation allowed |
| wr_blocked_o | output | 1 | Sticky: a write was refused while protected |

## Verification
The supply is moved through four physically ordered levels: below changeover, between changeover and lower level, inside the window, and fully up. Random jumps between these levels, with random write strobes, separate the deselect decode from the battery decode and check the gating of writes in each state. Directed power-up runs measure the exact edge at which ready appears. A drop back into the window during recovery shows whether the timer truly restarts or only pauses. Pulses one cycle shorter than the filter length and exactly as long as it mark the glitch-filter boundary.

// File: rtl/pf_pkg.sv
// Package: shared state type for the supply-loss write guard.
package pf_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL   = 2'd0,
        ST_DESELECT = 2'd1,
        ST_BATTERY  = 2'd2,
        ST_RECOVER  = 2'd3
    } pf_state_t;
endpackage

// File: rtl/pf_flag_filter.sv
// Synchronises one asynchronous comparator flag with two flops, then
// accepts a new level only after it has differed from the current output
// for FILT_LEN consecutive cycles. Assumes FILT_LEN >= 2. Output resets low.
module pf_flag_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flag_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          sync1_q, sync2_q;
    logic [CW-1:0] run_q;

    // Two-flop synchroniser for the raw comparator flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= raw_i;
            sync2_q <= sync1_q;
        end
    end

    // Persistence counter: flip the output after FILT_LEN differing cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            flag_o <= 1'b0;
        end else if (sync2_q == flag_o) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_LEN - 1)) begin
            run_q  <= '0;
            flag_o <= sync2_q;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R7
    flag_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o != $past(flag_o)) |-> ($past(sync2_q) != $past(flag_o)));

    // R7
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < CW'(FILT_LEN));
endmodule

// File: rtl/pf_recover_timer.sv
// Counts cycles while run_i is high and raises done_o on the last of
// REC_CYCLES cycles; dropping run_i clears the count. Assumes REC_CYCLES >= 2.
module pf_recover_timer #(
    parameter int REC_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int TW = $clog2(REC_CYCLES + 1);

    logic [TW-1:0] cnt_q;

    assign done_o = (cnt_q == TW'(REC_CYCLES - 1));

    // Recovery count: clear when idle, advance until done.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (!done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6
    timer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_i) |-> (cnt_q == '0));

    // R5
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < TW'(REC_CYCLES));
endmodule

// File: rtl/pf_state_ctrl.sv
// Four-state supply controller. Works from filtered flags only and assumes
// they are ordered physically (upper implies lower implies battery level).
// Battery level has top priority, then the power-fail window; full supply
// leads to normal operation only through a completed recovery wait.
module pf_state_ctrl
    import pf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hi_f_i,
    input  logic      lo_f_i,
    input  logic      bat_f_i,
    input  logic      rec_done_i,
    output pf_state_t state_o
);
    pf_state_t nxt;

    // Next-state decode with battery level first, then the window.
    always_comb begin
        if (!bat_f_i) begin
            nxt = ST_BATTERY;
        end else if (!(lo_f_i && hi_f_i)) begin
            nxt = ST_DESELECT;
        end else begin
            unique case (state_o)
                ST_NORMAL:  nxt = ST_NORMAL;
                ST_RECOVER: nxt = rec_done_i ? ST_NORMAL : ST_RECOVER;
                default:    nxt = ST_RECOVER;
            endcase
        end
    end

    // State register, starting on battery with the memory protected.
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= ST_BATTERY;
        else        state_o <= nxt;
    end

    // R3
    low_supply_battery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bat_f_i |=> (state_o == ST_BATTERY));

    // R5
    normal_via_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_NORMAL && $past(state_o) != ST_NORMAL)
            |-> ($past(state_o) == ST_RECOVER && $past(rec_done_i)));

    // R10
    normal_needs_full_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_NORMAL) |-> $past(hi_f_i && lo_f_i && bat_f_i));
endmodule

// File: rtl/pwrfail_guard.sv
// Top of the supply-loss write guard. Filters the three comparator flags,
// runs the state controller and recovery timer, gates the write strobe in
// the same cycle protection rises, and keeps a sticky refused-write flag.
// Assumes the flags come from comparators on the same supply.
module pwrfail_guard
    import pf_pkg::*;
#(
    parameter int FILT_LEN   = 3,
    parameter int REC_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_above_hi_i,
    input  logic sup_above_lo_i,
    input  logic sup_above_bat_i,
    input  logic wr_strobe_i,
    output logic wr_en_o,
    output logic wr_protect_o,
    output logic out_hiz_o,
    output logic bat_sel_o,
    output logic ready_o,
    output logic wr_blocked_o
);
    localparam int NFLAG = 3;

    logic [NFLAG-1:0] raw_flags;
    logic [NFLAG-1:0] filt_flags;
    logic             rec_done;
    pf_state_t        state;

    assign raw_flags = {sup_above_bat_i, sup_above_lo_i, sup_above_hi_i};

    // One conditioner per comparator flag.
    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        pf_flag_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_flags[gi]),
            .flag_o (filt_flags[gi])
        );
    end

    pf_state_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hi_f_i     (filt_flags[0]),
        .lo_f_i     (filt_flags[1]),
        .bat_f_i    (filt_flags[2]),
        .rec_done_i (rec_done),
        .state_o    (state)
    );

    pf_recover_timer #(.REC_CYCLES(REC_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state == ST_RECOVER),
        .done_o (rec_done)
    );

    // Output decode from the controller state.
    always_comb begin
        ready_o      = (state == ST_NORMAL);
        wr_protect_o = !ready_o;
        out_hiz_o    = !ready_o;
        bat_sel_o    = (state == ST_BATTERY);
        wr_en_o      = wr_strobe_i && ready_o;
    end

    // Sticky record of a write refused under protection.
    always_ff @(posedge clk) begin
        if (!rst_n)                           wr_blocked_o <= 1'b0;
        else if (wr_strobe_i && wr_protect_o) wr_blocked_o <= 1'b1;
    end

    // R9
    blocked_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_blocked_o) |-> wr_blocked_o);

    // R9
    blocked_on_refusal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe_i && wr_protect_o) |=> wr_blocked_o);

    // R4
    external_when_bat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(filt_flags[2]) |-> !bat_sel_o);
endmodule

// File: tb/sim_pwrfail_guard.sv
`timescale 1ns/1ps
// Bench for pwrfail_guard: directed supply sequences plus seeded random
// level jumps with write strobes, checked against bench-side models.
module sim_pwrfail_guard;
    localparam int F   = 3;
    localparam int REC = 16;
    localparam int LAT = F + REC + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi = 1'b0, lo = 1'b0, bat = 1'b0, strobe = 1'b0;
    logic wr_en, prot, hiz, bsel, rdy, blk;
    int   checks = 0;
    int   failures = 0;
    logic exp_blk = 1'b0;

    always #2 clk = ~clk;

    pwrfail_guard #(.FILT_LEN(F), .REC_CYCLES(REC)) u0 (
        .clk(clk), .rst_n(rst_n),
        .sup_above_hi_i(hi), .sup_above_lo_i(lo), .sup_above_bat_i(bat),
        .wr_strobe_i(strobe), .wr_en_o(wr_en), .wr_protect_o(prot),
        .out_hiz_o(hiz), .bat_sel_o(bsel), .ready_o(rdy), .wr_blocked_o(blk)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Level 0: below changeover, 1: below lower level, 2: in window, 3: up.
    task automatic set_lvl(input int l);
        @(negedge clk);
        bat = (l >= 1);
        lo  = (l >= 2);
        hi  = (l == 3);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Settled output model: {protect, hiz, bat_sel, ready}.
    function automatic logic [3:0] exp_out(input int l);
        if (l == 0)      return 4'b1110;
        else if (l < 3)  return 4'b1100;
        else             return 4'b0001;
    endfunction

    task automatic chk_settled(input string req, input int l);
        chk(req, {prot, hiz, bsel, rdy}, exp_out(l));
    endtask

    // Count edges from a rise until ready appears; ready must stay low before.
    task automatic measure_rise(input string req);
        int n = 0;
        bit seen = 0;
        for (int k = 1; k <= LAT + 10 && !seen; k++) begin
            tick(1);
            if (rdy) begin n = k; seen = 1; end
            else chk({req, " protect held"}, prot, 1);
        end
        chk({req, " ready latency"}, n, LAT);
    endtask

    // Strobe for one cycle and check gating plus the sticky flag.
    task automatic strobe_once(input int l);
        @(negedge clk);
        strobe = 1'b1;
        #1;
        chk("R8 wr_en gating", wr_en, (l == 3) ? 1 : 0);
        if (l != 3) exp_blk = 1'b1;
        tick(1);
        strobe = 1'b0;
        chk("R9 blocked sticky", blk, exp_blk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(3);
        // R1 reset state
        chk("R1 reset outputs", {prot, hiz, bsel, rdy, wr_en, blk}, 6'b111000);
        @(negedge clk); rst_n = 1'b1;
        tick(1);
        chk("R1 after reset", {prot, hiz, bsel, rdy, wr_en, blk}, 6'b111000);

        // R3 strobe on battery is refused
        strobe_once(0);

        // R5 / R10 power-up from battery
        set_lvl(3);
        measure_rise("R5");
        chk_settled("R10 normal outputs", 3);
        strobe_once(3);

        // R2 window
        set_lvl(2); tick(F + 6);
        chk_settled("R2 window", 2);
        strobe_once(2);
        // R2 / R4 between changeover and lower level
        set_lvl(1); tick(F + 6);
        chk_settled("R4 external supply", 1);
        // R3 below changeover
        set_lvl(0); tick(F + 6);
        chk_settled("R3 battery", 0);

        // R4 / R6 restart of recovery
        set_lvl(3); tick(F + 4);
        chk("R4 external during recovery", bsel, 0);
        tick(6);
        chk("R6 still recovering", rdy, 0);
        set_lvl(2);
        for (int k = 0; k < 8; k++) begin
            tick(1);
            chk("R6 ready stays low", rdy, 0);
        end
        set_lvl(3);
        measure_rise("R6");

        // R7 short glitch ignored
        set_lvl(2);
        repeat (F - 1) @(posedge clk);
        set_lvl(3);
        for (int k = 0; k < F + 8; k++) begin
            tick(1);
            chk("R7 short glitch ignored", {prot, rdy}, 2'b01);
        end
        // R7 glitch of FILT_LEN cycles takes effect
        set_lvl(2);
        repeat (F) @(posedge clk);
        set_lvl(3);
        tick(F + 6);
        chk("R7 long glitch acts", rdy, 0);
        tick(LAT);
        chk_settled("R7 recovered", 3);

        // Random level jumps with strobes
        for (int it = 0; it < 60; it++) begin
            int l = $urandom_range(3, 0);
            set_lvl(l);
            tick(LAT + 4);
            chk_settled("R2 R3 R10 random settle", l);
            if ($urandom_range(1, 0) == 1) strobe_once(l);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule